// File: doc/BRIEF.md
# Turn Clock Delay Generator

This block produces the local turn clock for a receiver that runs on the bunch clock (one cycle per 25 ns bunch slot). The turn reference comes either from the received orbit trigger (external mode) or from a divider of the bunch clock (internal mode). The divider and the delay range follow one of two revolution lengths: 3564 or 924 bunch clocks. Each reference pulse starts a programmable delay of whole bunch-clock steps, up to one revolution less one step. When the delay expires the block emits a one-cycle delayed turn pulse.

The block also watches the stream of received message bytes, each a subaddress with a data byte. For two host-chosen subaddresses it keeps the most recent data byte. On each delayed turn pulse it loads these two bytes onto hardware output ports, each with a one-cycle strobe. A presence flag tells whether a turn reference has been seen recently.

Top module: `turn_delay_gen`

## Requirements
- R1: After reset, `turn_out`, both strobes, both hardware bytes and `present` are 0.
- R2: With `int_mode`=1 and `short_ring`=0, `turn_out` pulses exactly every 3564 cycles.
- R3: With `int_mode`=1 and `short_ring`=1, `turn_out` pulses exactly every 924 cycles.
- R4: In external mode, a `trig_in` high sampled at clock edge E with delay d gives `turn_out` high for exactly one cycle, the cycle after edge E+d. This includes d=0.
- R5: A `delay_set` value at or above the revolution length (3564 or 924) acts as that length minus one.
- R6: A reference pulse that arrives while a delay is counting restarts the count from the new pulse. The earlier count gives no pulse. A reference that coincides with expiry also restarts.
- R7: `hw_byte0`/`hw_byte1` take the last data byte written with subaddress `sel0`/`sel1` before the firing edge. They change at the same edge as `turn_out` rises, and `hw_stb0`/`hw_stb1` are high for that one cycle.
- R8: With `hw_en`=0, a delayed turn pulse raises no strobe and leaves both hardware bytes unchanged.
- R9: `present` goes to 1 on a reference pulse. It returns to 0 after 2×(revolution length) cycles with no new reference pulse: high after edges E..E+2L-1, low after E+2L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_mode | input | 1 | 1: local divider is the turn reference; 0: received trigger |
| short_ring | input | 1 | 1: revolution of 924 clocks; 0: 3564 clocks |
| trig_in | input | 1 | Received orbit trigger, one cycle per turn |
| delay_set | input | 12 | Turn delay in bunch-clock steps |
| msg_we | input | 1 | Received message byte valid |
| msg_addr | input | 8 | Subaddress of the received byte |
| msg_data | input | 8 | Data of the received byte |
| sel0 | input | 8 | Subaddress routed to hardware byte 0 |
| sel1 | input | 8 | Subaddress routed to hardware byte 1 |
| hw_en | input | 1 | Enables the hardware byte outputs |
| turn_out | output | 1 | Delayed turn pulse, one cycle wide |
| hw_byte0 | output | 8 | Hardware byte 0 |
| hw_stb0 | output | 1 | Strobe for hardware byte 0 |
| hw_byte1 | output | 8 | Hardware byte 1 |
| hw_stb1 | output | 1 | Strobe for hardware byte 1 |
| present | output | 1 | Turn reference seen within the last two revolutions |

## Verification
The bench places pulses at random delays, including zero and the clamp edges in both ring modes. An off-by-one counter shows up as a pulse one slot early or late, and a missing clamp as a pulse that never arrives inside the window. A retrigger in the middle of a count must move the pulse; a design that let the first count run on would emit two pulses. Byte routing is driven with random writes that often hit the selected subaddresses, so a design that latched the wrong subaddress or a stale byte gives a wrong value at the strobe. The presence flag is checked on the exact cycle it must drop, which exposes a window one cycle too short or too long.

// File: rtl/turn_delay_gen.sv
module turn_delay_gen #(
  parameter int DW         = 12,
  parameter int BW         = 8,
  parameter int AW         = 8,
  parameter int LONG_TURN  = 3564,
  parameter int SHORT_TURN = 924
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_mode,
  input  logic          short_ring,
  input  logic          trig_in,
  input  logic [DW-1:0] delay_set,
  input  logic          msg_we,
  input  logic [AW-1:0] msg_addr,
  input  logic [BW-1:0] msg_data,
  input  logic [AW-1:0] sel0,
  input  logic [AW-1:0] sel1,
  input  logic          hw_en,
  output logic          turn_out,
  output logic [BW-1:0] hw_byte0,
  output logic          hw_stb0,
  output logic [BW-1:0] hw_byte1,
  output logic          hw_stb1,
  output logic          present
);
  localparam int GW = DW + 1;

  logic [DW-1:0] len, eff, div_cnt, cnt;
  logic [GW-1:0] gap, twice;
  logic [BW-1:0] sh0, sh1;
  logic          div_tick, src, busy, fire;

  assign len      = short_ring ? SHORT_TURN[DW-1:0] : LONG_TURN[DW-1:0];
  assign twice    = {len, 1'b0};
  assign eff      = (delay_set >= len) ? len - 1'b1 : delay_set;
  assign div_tick = int_mode && (div_cnt >= len - 1'b1);
  assign src      = int_mode ? div_tick : trig_in;
  assign fire     = src ? (eff == '0) : (busy && cnt == DW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) div_cnt <= '0;
    else if (div_cnt >= len - 1'b1) div_cnt <= '0;
    else div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      turn_out <= 1'b0;
    end else begin
      turn_out <= fire;
      if (src) begin
        busy <= (eff != '0);
        cnt  <= eff;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
        if (cnt == DW'(1)) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh0      <= '0;
      sh1      <= '0;
      hw_byte0 <= '0;
      hw_byte1 <= '0;
      hw_stb0  <= 1'b0;
      hw_stb1  <= 1'b0;
    end else begin
      if (msg_we && msg_addr == sel0) sh0 <= msg_data;
      if (msg_we && msg_addr == sel1) sh1 <= msg_data;
      hw_stb0 <= fire && hw_en;
      hw_stb1 <= fire && hw_en;
      if (fire && hw_en) begin
        hw_byte0 <= sh0;
        hw_byte1 <= sh1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap     <= '0;
      present <= 1'b0;
    end else if (src) begin
      gap     <= '0;
      present <= 1'b1;
    end else begin
      if (gap != '1) gap <= gap + 1'b1;
      if (gap == twice - 1'b1) present <= 1'b0;
    end
  end

  AST_CNT_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < LONG_TURN[DW-1:0])); // R5
  AST_STB0_ON_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stb0 |-> turn_out); // R7
  AST_STB1_ON_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stb1 |-> turn_out); // R7
  AST_STB_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_stb0 || hw_stb1) |-> $past(hw_en)); // R8
  AST_BYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !turn_out |-> ($stable(hw_byte0) && $stable(hw_byte1))); // R8
  AST_PRESENT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(src) |-> present); // R9
endmodule

// File: tb/sim_turn_delay_gen.sv
module sim_turn_delay_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic int_mode = 0, short_ring = 0, trig_in = 0, msg_we = 0, hw_en = 0;
  logic [11:0] delay_set = '0;
  logic [7:0] msg_addr = '0, msg_data = '0, sel0 = '0, sel1 = '0;
  logic turn_out, hw_stb0, hw_stb1, present;
  logic [7:0] hw_byte0, hw_byte1;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] model [256];
  int first_k, n_hi, cap_s0, cap_s1;
  logic [7:0] cap_b0, cap_b1;

  turn_delay_gen u0 (.clk(clk), .rst_n(rst_n), .int_mode(int_mode), .short_ring(short_ring),
    .trig_in(trig_in), .delay_set(delay_set), .msg_we(msg_we), .msg_addr(msg_addr),
    .msg_data(msg_data), .sel0(sel0), .sel1(sel1), .hw_en(hw_en), .turn_out(turn_out),
    .hw_byte0(hw_byte0), .hw_stb0(hw_stb0), .hw_byte1(hw_byte1), .hw_stb1(hw_stb1),
    .present(present));

  always #5 clk = ~clk;

  function automatic int ring_len(bit s);
    return s ? 924 : 3564;
  endfunction

  function automatic int exp_delay(int d, bit s);
    return (d >= ring_len(s)) ? ring_len(s) - 1 : d;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_msg(logic [7:0] a, logic [7:0] d);
    msg_we = 1; msg_addr = a; msg_data = d;
    @(negedge clk);
    msg_we = 0;
    model[a] = d;
  endtask

  // fires a trigger, watches `span` cycles, records first pulse offset and width
  task automatic trig_watch(int d, int span);
    delay_set = 12'(d);
    trig_in = 1;
    @(negedge clk);
    trig_in = 0;
    first_k = -1; n_hi = 0; cap_s0 = 0; cap_s1 = 0;
    for (int k = 0; k <= span; k++) begin
      if (turn_out) begin
        if (first_k < 0) begin
          first_k = k;
          cap_b0 = hw_byte0; cap_b1 = hw_byte1;
          cap_s0 = hw_stb0; cap_s1 = hw_stb1;
        end
        n_hi++;
      end
      @(negedge clk);
    end
  endtask

  task automatic wait_pulse(output int ok);
    ok = 0;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (turn_out) begin ok = 1; break; end
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(10 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    int d, e, ok, per;
    logic [7:0] a, v, keep0, keep1;
    void'($urandom(32'd5150));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!turn_out && !hw_stb0 && !hw_stb1, "R1 pulses", int'(turn_out) + int'(hw_stb0), 0);
    chk(hw_byte0 == 0 && hw_byte1 == 0, "R1 bytes", int'(hw_byte0), 0);
    chk(!present, "R1 present", int'(present), 0);

    // R4 random delays in both rings, with d=0
    for (int i = 0; i < 8; i++) begin
      short_ring = i[0];
      d = (i == 0) ? 0 : int'($urandom % 300);
      trig_watch(d, d + 4);
      chk(first_k == d && n_hi == 1, "R4 delay position", first_k, d);
    end

    // R5 clamp
    short_ring = 1;
    e = exp_delay(2000, 1);
    trig_watch(2000, e + 4);
    chk(first_k == e && n_hi == 1, "R5 clamp short", first_k, e);
    short_ring = 0;
    e = exp_delay(4000, 0);
    trig_watch(4000, e + 4);
    chk(first_k == e && n_hi == 1, "R5 clamp long", first_k, e);

    // R6 retrigger
    short_ring = 1;
    trig_watch(50, 19);
    d = n_hi;
    trig_watch(50, 60);
    chk(d == 0 && n_hi == 1 && first_k == 50, "R6 restart", first_k + 100 * (d + n_hi - 1), 50);

    // R7 byte routing with random messages
    hw_en = 1;
    for (int i = 0; i < 6; i++) begin
      sel0 = 8'($urandom);
      sel1 = sel0 ^ 8'(1 + $urandom % 255);
      for (int j = 0; j < 10; j++) begin
        case ($urandom % 3)
          0: a = sel0;
          1: a = sel1;
          default: a = 8'($urandom);
        endcase
        v = 8'($urandom);
        put_msg(a, v);
      end
      d = int'($urandom % 20);
      trig_watch(d, d + 3);
      chk(cap_s0 == 1 && cap_b0 == model[sel0], "R7 byte0", int'(cap_b0), int'(model[sel0]));
      chk(cap_s1 == 1 && cap_b1 == model[sel1], "R7 byte1", int'(cap_b1), int'(model[sel1]));
    end

    // R8 outputs disabled
    keep0 = hw_byte0; keep1 = hw_byte1;
    put_msg(sel0, ~keep0);
    put_msg(sel1, ~keep1);
    hw_en = 0;
    trig_watch(3, 6);
    chk(n_hi == 1 && cap_s0 == 0 && cap_s1 == 0, "R8 no strobe", cap_s0 + cap_s1, 0);
    chk(hw_byte0 == keep0 && hw_byte1 == keep1, "R8 bytes hold", int'(hw_byte0), int'(keep0));

    // R3 / R2 internal divider
    int_mode = 1; short_ring = 1; delay_set = 12'd7;
    wait_pulse(ok);
    per = 0;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk); per++;
      if (turn_out) break;
    end
    chk(ok == 1 && per == 924, "R3 short period", per, 924);
    short_ring = 0;
    wait_pulse(ok);
    per = 0;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk); per++;
      if (turn_out) break;
    end
    chk(ok == 1 && per == 3564, "R2 long period", per, 3564);
    int_mode = 0;
    repeat (3600) @(negedge clk);

    // R9 presence window
    short_ring = 1;
    delay_set = 12'd0;
    trig_in = 1;
    @(negedge clk);
    trig_in = 0;
    for (int k = 0; k <= 1848; k++) begin
      if (k == 0)    chk(present == 1, "R9 set", int'(present), 1);
      if (k == 1847) chk(present == 1, "R9 last high", int'(present), 1);
      if (k == 1848) chk(present == 0, "R9 dropped", int'(present), 0);
      @(negedge clk);
    end
    finish_up();
  end
endmodule